// File: doc/BRIEF.md
# Debounced Multi-Channel Overvoltage Monitor

This block watches three voltage-sense channels for an overvoltage condition. It has three detection paths. Channel one has a slow path that works on ADC sample codes and a fast path that works on a separate code every clock. Channels two and three share a single slow path. Each path compares its reading against its own threshold. A path raises its flag only after the condition has held for a programmable debounce run.

The slow paths are evaluated only on cycles where `sample_tick` is high, which is a strobe expected once per 80 µs sample period. The debounce field on a slow path adds 0 to 3 extra sample periods. The fast path is evaluated on every clock and its debounce field adds 0 to 15 extra cycles. A reading at or below its threshold resets that path's run, so a path trips only on consecutive over-threshold evaluations. The shared path judges the larger of its two readings and records which channel caused the trip. Flags stay set until `flag_clr` is pulsed. Actions taken on a flag are left to the logic that reads it.

Top module: `ovp_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all three flags and `pair_src` are 0.
- R2: The channel-one slow flag `ch1_ovp` becomes 1 on the cycle after the tick that completes `ch1_dbnc`+1 consecutive ticked evaluations with `ch1_code` > `ch1_thr`.
- R3: On a slow path, a ticked evaluation whose code is at or below the threshold restarts that path's run from zero. Cycles with `sample_tick` low evaluate nothing and leave the run unchanged.
- R4: The shared flag `pair_ovp` follows the rule of R2 using max(`ch2_code`, `ch3_code`) against `pair_thr`, with debounce `pair_dbnc`.
- R5: `pair_src` is loaded at the tick that sets `pair_ovp`: it is 1 if `ch3_code` > `ch2_code` and 0 otherwise, so a tie gives 0. It holds that value while `pair_ovp` stays set.
- R6: The fast flag `fast_ovp` becomes 1 after `fast_dbnc`+1 consecutive clock cycles with `fast_code` > `fast_thr`, where `fast_dbnc` is 4 bits (0 to 15). A cycle at or below the threshold restarts the run.
- R7: Once set, a flag stays 1 regardless of later readings until `flag_clr` is sampled high. `flag_clr` clears all flags and all runs, and it takes priority over a set on the same cycle.
- R8: The comparison is strict, so a code equal to its threshold never counts as over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | Slow-path evaluation strobe, one cycle per sample period |
| ch1_code | input | DW | Channel-one ADC code |
| ch2_code | input | DW | Channel-two ADC code |
| ch3_code | input | DW | Channel-three ADC code |
| fast_code | input | DW | Channel-one fast comparator reading |
| ch1_thr | input | DW | Channel-one slow threshold |
| pair_thr | input | DW | Shared-path threshold |
| fast_thr | input | DW | Fast-path threshold |
| ch1_dbnc | input | SDW | Channel-one extra sample periods |
| pair_dbnc | input | SDW | Shared-path extra sample periods |
| fast_dbnc | input | FDW | Fast-path extra cycles |
| flag_clr | input | 1 | Clears all flags and runs |
| ch1_ovp | output | 1 | Channel-one slow overvoltage flag |
| pair_ovp | output | 1 | Shared-path overvoltage flag |
| pair_src | output | 1 | Channel that tripped the shared path (1 = channel three) |
| fast_ovp | output | 1 | Fast overvoltage flag |

## Verification
The hardest case to reach is a run broken by a single at-threshold sample that is separated from the final qualifying tick by idle cycles. It needs long sequences of ticks whose codes sit exactly on the threshold boundary. Directed sequences build these runs tick by tick and also cover the longest fast debounce of 16 cycles. Random stimulus then keeps the codes clustered within a few counts of each threshold and keeps clears rare, so runs of every length, ties between channels two and three, and clears that coincide with a set all occur often.

// File: rtl/ovp_monitor.sv
module ovp_monitor #(
  parameter int DW  = 12,
  parameter int SDW = 2,
  parameter int FDW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_tick,
  input  logic [DW-1:0]  ch1_code,
  input  logic [DW-1:0]  ch2_code,
  input  logic [DW-1:0]  ch3_code,
  input  logic [DW-1:0]  fast_code,
  input  logic [DW-1:0]  ch1_thr,
  input  logic [DW-1:0]  pair_thr,
  input  logic [DW-1:0]  fast_thr,
  input  logic [SDW-1:0] ch1_dbnc,
  input  logic [SDW-1:0] pair_dbnc,
  input  logic [FDW-1:0] fast_dbnc,
  input  logic           flag_clr,
  output logic           ch1_ovp,
  output logic           pair_ovp,
  output logic           pair_src,
  output logic           fast_ovp
);

  logic [SDW-1:0] c1_run, pr_run;
  logic [FDW-1:0] f_run;

  wire          c3_big   = ch3_code > ch2_code;
  wire [DW-1:0] pair_max = c3_big ? ch3_code : ch2_code;
  wire          c1_over  = ch1_code > ch1_thr;
  wire          pr_over  = pair_max > pair_thr;
  wire          f_over   = fast_code > fast_thr;

  always_ff @(posedge clk) begin
    if (!rst_n || flag_clr) begin
      ch1_ovp  <= 1'b0;
      pair_ovp <= 1'b0;
      pair_src <= 1'b0;
      fast_ovp <= 1'b0;
      c1_run   <= '0;
      pr_run   <= '0;
      f_run    <= '0;
    end else begin
      if (sample_tick) begin
        if (!c1_over) c1_run <= '0;
        else if (!ch1_ovp) begin
          if (c1_run >= ch1_dbnc) ch1_ovp <= 1'b1;
          else c1_run <= c1_run + 1'b1;
        end
        if (!pr_over) pr_run <= '0;
        else if (!pair_ovp) begin
          if (pr_run >= pair_dbnc) begin
            pair_ovp <= 1'b1;
            pair_src <= c3_big;
          end else pr_run <= pr_run + 1'b1;
        end
      end
      if (!f_over) f_run <= '0;
      else if (!fast_ovp) begin
        if (f_run >= fast_dbnc) fast_ovp <= 1'b1;
        else f_run <= f_run + 1'b1;
      end
    end
  end

  assert_ch1_set_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ch1_ovp) |-> $past(sample_tick) && $past(ch1_code > ch1_thr));
  assert_pair_set_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_ovp) |-> $past(sample_tick) &&
      ($past(ch2_code > pair_thr) || $past(ch3_code > pair_thr)));
  assert_src_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pair_ovp && $past(pair_ovp) |-> $stable(pair_src));
  assert_fast_set_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_ovp) |-> $past(fast_code > fast_thr));
  assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_clr) && $past(rst_n) |-> !ch1_ovp && !pair_ovp && !fast_ovp);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ch1_ovp) || $fell(pair_ovp) || $fell(fast_ovp) |-> $past(flag_clr));

endmodule

// File: tb/ovp_monitor_tb.sv
module ovp_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 0, rst_n = 0, tick = 0, clr = 0;
  logic [DW-1:0] c1 = 0, c2 = 0, c3 = 0, fc = 0, t1 = 0, tp = 0, tf = 0;
  logic [1:0] d1 = 0, dp = 0;
  logic [3:0] df = 0;
  logic o1, op, os, of;
  int checks = 0, fails = 0;
  bit model_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovp_monitor #(.DW(DW), .SDW(2), .FDW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_tick(tick),
    .ch1_code(c1), .ch2_code(c2), .ch3_code(c3), .fast_code(fc),
    .ch1_thr(t1), .pair_thr(tp), .fast_thr(tf),
    .ch1_dbnc(d1), .pair_dbnc(dp), .fast_dbnc(df), .flag_clr(clr),
    .ch1_ovp(o1), .pair_ovp(op), .pair_src(os), .fast_ovp(of));

  // reference model built from the requirements
  bit m1, mp, ms, mf;
  int r1, rp, rf;

  function automatic int maxv(int a, int b);
    return (a > b) ? a : b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      m1 <= 0; mp <= 0; ms <= 0; mf <= 0; r1 <= 0; rp <= 0; rf <= 0;
    end else begin
      if (tick) begin
        if (!(c1 > t1)) r1 <= 0;
        else if (!m1) begin if (r1 + 1 > d1) m1 <= 1; else r1 <= r1 + 1; end
        if (!(maxv(c2, c3) > tp)) rp <= 0;
        else if (!mp) begin
          if (rp + 1 > dp) begin mp <= 1; ms <= (c3 > c2); end else rp <= rp + 1;
        end
      end
      if (!(fc > tf)) rf <= 0;
      else if (!mf) begin if (rf + 1 > df) mf <= 1; else rf <= rf + 1; end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on) begin
    check("R2 model ch1_ovp", o1, m1);
    check("R4 model pair_ovp", op, mp);
    check("R5 model pair_src", os, ms);
    check("R6 model fast_ovp", of, mf);
  end

  task automatic step(bit t);
    tick = t;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic pulse_clr();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    t1 = 1000; tp = 500; tf = 2000; d1 = 3; dp = 0; df = 15;
    repeat (3) @(negedge clk);
    check("R1 reset ch1", o1, 0); check("R1 reset pair", op, 0);
    check("R1 reset src", os, 0); check("R1 reset fast", of, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", o1 | op | os | of, 0);
    model_on = 1;

    // R2 / R3 / R8: run broken by equal-to-threshold sample
    c1 = 1001; step(1); step(1);
    c1 = 1000; step(1);
    check("R8 equal not over", o1, 0);
    c1 = 1001; step(1); step(1); step(1);
    check("R3 run restarted", o1, 0);
    c1 = 0; repeat (5) step(0);
    check("R3 idle cycles ignored", o1, 0);
    c1 = 1001; step(1);
    check("R2 fourth tick sets", o1, 1);
    c1 = 0; step(1);
    check("R7 sticky", o1, 1);
    pulse_clr();
    check("R7 cleared", o1, 0);

    // R4 / R5 shared path
    c2 = 400; c3 = 600; step(1);
    check("R4 shared sets", op, 1); check("R5 src ch3", os, 1);
    pulse_clr();
    c2 = 700; c3 = 700; step(1);
    check("R5 tie src ch2", os, 0);
    c3 = 900; step(1);
    check("R5 src held", os, 0);
    pulse_clr();
    c2 = 500; c3 = 500; step(1);
    check("R8 shared equal", op, 0);

    // R6 fast path, longest debounce
    fc = 2001;
    repeat (15) step(0);
    check("R6 15 cycles not yet", of, 0);
    step(0);
    check("R6 16th cycle sets", of, 1);
    fc = 0;

    // R7 clear beats same-cycle set
    pulse_clr();
    c2 = 900; tick = 1; clr = 1; @(negedge clk); tick = 0; clr = 0;
    check("R7 clear priority", op, 0);
    c2 = 0;

    // random phase, codes near thresholds
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 63) == 0) begin
        d1 = 2'($urandom); dp = 2'($urandom); df = 4'($urandom_range(0, 6));
      end
      c1 = DW'(t1 - 2 + $urandom_range(0, 4));
      c2 = DW'(tp - 3 + $urandom_range(0, 5));
      c3 = DW'(tp - 3 + $urandom_range(0, 5));
      fc = DW'(tf - 1 + $urandom_range(0, 4));
      clr = ($urandom_range(0, 39) == 0);
      tick = ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    tick = 0; clr = 0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule